// File: doc/BRIEF.md
# Banked Microcode Store Read Path

This block is the synchronous read side of a fixed microcode store of 4608 words, each 90 bits wide. The store is built from two banks. Each bank holds 288 rows of 720 cells and returns 45 bits. The bank outputs are joined into one micro-instruction word. A sequencer presents a 13-bit micro-address together with a read strobe. One clock later the block returns the registered word, a valid flag and a flag for an address that lies outside the populated rows.

The address is split into three fields. The upper six bits pick a group of eight rows. The next three bits are predecoded to one of eight lines, and each row combines its group match with one of those lines. The low four bits pick one of sixteen physical columns for every output bit. That pick goes through a first rank of four 4-to-1 selectors and then a final 4-to-1 selector. A parameter mask mirrors the column order inside chosen 16-column groups. Cell contents come from a fixed hash of bank, row and column, so no memory image is needed.

Top module: `mrom_read_path`

## Requirements
- R1: While reset is asserted, `uinst` is all zeros and `uinst_vld` and `addr_oor` are low.
- R2: A read with `rd_en` high at a rising edge updates `uinst` and `addr_oor` at that edge, and `uinst_vld` is high in the following cycle. `uinst_vld` is low after any edge at which `rd_en` was low.
- R3: When `rd_en` is low at an edge, `uinst` and `addr_oor` keep their values.
- R4: Address bits [12:7] select the row group, bits [6:4] select the row inside the group, and bits [3:0] select the column. The physical row is r = addr[12:4].
- R5: The cell at bank b, row r and physical column c holds the XOR-reduction of the low 12 bits of (29·r) XOR (7·c) XOR (1365·b). Output bit n = 45·b + k takes its value from column 16·k + s of bank b, where s is the column select. Bank 0 drives bits [44:0] and bank 1 drives bits [89:45].
- R6: When bit n of the parameter `REV_MASK` is set, output bit n reads column 16·k + (15 − s) instead of 16·k + s.
- R7: When the group field is 36 or above, the read returns all ones and `addr_oor` goes high. For a group field below 36, `addr_oor` is low after the read.
- R8: For every in-range address the row decoder raises exactly one row line. For an out-of-range group it raises none. The lowest row (0) and the highest row (287) both read correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized on release |
| rd_en | input | 1 | Read strobe; the address is captured when high |
| rd_addr | input | 13 | Micro-address: group, sub-row and column fields |
| uinst | output | 90 | Registered micro-instruction word |
| uinst_vld | output | 1 | High in the cycle after a read |
| addr_oor | output | 1 | Registered out-of-range flag for the last read |

## Verification
The assertions check on every cycle four things: the row decoder gives a single row line for in-range groups and none otherwise; the valid flag follows the strobe by one cycle; the registered word and flag hold while idle; and an out-of-range read yields all ones with the flag raised. Cell values, the bit placement of each bank, the column mirroring of masked groups, and correct reads at the row and column extremes can only be shown by the bench's directed reads. The bench compares each read against words it computes itself from the stated cell hash and the mask.

// File: rtl/mrom_pkg.sv
package mrom_pkg;

  // Fixed cell contents: parity of a small hash of bank, row and column.
  function automatic logic mrom_cell(input int unsigned bank,
                                     input int unsigned row,
                                     input int unsigned col);
    logic [11:0] h;
    h = 12'(row * 29) ^ 12'(col * 7) ^ 12'(bank * 1365);
    return ^h;
  endfunction

endpackage

// File: rtl/mrom_row_decode.sv
module mrom_row_decode #(
  parameter int GRP_W = 6,
  parameter int SUB_W = 3,
  parameter int N_GRP = 36
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [GRP_W-1:0]                grp,
  input  logic [SUB_W-1:0]                sub,
  output logic [N_GRP*(1<<SUB_W)-1:0]     row_sel,
  output logic                            oor
);
  localparam int N_SUB = 1 << SUB_W;

  logic [N_SUB-1:0] pre;

  // one-of-eight predecode, computed once for all groups
  always_comb begin
    pre      = '0;
    pre[sub] = 1'b1;
  end

  assign oor = (grp >= GRP_W'(N_GRP));

  // per-group match combined with the predecoded line
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic hit;
    assign hit = (grp == GRP_W'(g));
    for (genvar i = 0; i < N_SUB; i++) begin : g_row
      assign row_sel[g*N_SUB+i] = hit & pre[i];
    end
  end

  // R8: exactly one row line for a populated group
  a_r8_onehot_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !oor |-> ($countones(row_sel) == 1));

  // R8: no row line for an unpopulated group
  a_r8_none_oor: assert property (@(posedge clk) disable iff (!rst_n)
    oor |-> (row_sel == '0));

endmodule

// File: rtl/mrom_col_mux.sv
module mrom_col_mux #(
  parameter bit REV = 1'b0
) (
  input  logic [15:0] col,
  input  logic [3:0]  sel,
  output logic        bit_o
);
  logic [3:0] eff;
  logic [3:0] s1;

  // mirrored groups walk their columns from the top
  if (REV) begin : g_rev
    assign eff = ~sel;
  end else begin : g_fwd
    assign eff = sel;
  end

  // first rank: four 4-to-1 selectors
  for (genvar i = 0; i < 4; i++) begin : g_s1
    assign s1[i] = col[4*i + int'(eff[1:0])];
  end

  // final 4-to-1 selector
  assign bit_o = s1[eff[3:2]];

endmodule

// File: rtl/mrom_bank.sv
module mrom_bank #(
  parameter int                 BANK  = 0,
  parameter int                 BITS  = 45,
  parameter int                 ROWS  = 288,
  parameter logic [BITS-1:0]    REV   = '0
) (
  input  logic [ROWS-1:0] row_sel,
  input  logic [3:0]      col_sel,
  output logic [BITS-1:0] dout
);
  import mrom_pkg::*;

  localparam int ROW_W = $clog2(ROWS);
  localparam int N_COL = 16;

  logic [ROW_W-1:0] row_idx;

  // word line back to row number for the content function
  always_comb begin
    row_idx = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (row_sel[r]) row_idx = row_idx | ROW_W'(r);
    end
  end

  for (genvar k = 0; k < BITS; k++) begin : g_bit
    logic [N_COL-1:0] line;
    for (genvar c = 0; c < N_COL; c++) begin : g_col
      assign line[c] = mrom_cell(BANK, int'(row_idx), k*N_COL + c);
    end
    mrom_col_mux #(.REV(REV[k])) u_mux (
      .col   (line),
      .sel   (col_sel),
      .bit_o (dout[k])
    );
  end

endmodule

// File: rtl/mrom_read_path.sv
module mrom_read_path #(
  parameter int GRP_W     = 6,
  parameter int SUB_W     = 3,
  parameter int COL_W     = 4,
  parameter int N_GRP     = 36,
  parameter int N_BANKS   = 2,
  parameter int BANK_BITS = 45,
  parameter logic [N_BANKS*BANK_BITS-1:0] REV_MASK = {6{15'h4C71}}
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rd_en,
  input  logic [GRP_W+SUB_W+COL_W-1:0]     rd_addr,
  output logic [N_BANKS*BANK_BITS-1:0]     uinst,
  output logic                             uinst_vld,
  output logic                             addr_oor
);
  localparam int ADDR_W = GRP_W + SUB_W + COL_W;
  localparam int WORD_W = N_BANKS * BANK_BITS;
  localparam int ROWS   = N_GRP * (1 << SUB_W);

  logic [GRP_W-1:0]  grp;
  logic [SUB_W-1:0]  sub;
  logic [COL_W-1:0]  csel;
  logic [ROWS-1:0]   row_sel;
  logic              oor_c;
  logic [WORD_W-1:0] raw;
  logic [WORD_W-1:0] word_d;

  assign grp  = rd_addr[ADDR_W-1 -: GRP_W];
  assign sub  = rd_addr[COL_W +: SUB_W];
  assign csel = rd_addr[COL_W-1:0];

  mrom_row_decode #(.GRP_W(GRP_W), .SUB_W(SUB_W), .N_GRP(N_GRP)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .grp     (grp),
    .sub     (sub),
    .row_sel (row_sel),
    .oor     (oor_c)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    mrom_bank #(
      .BANK (b),
      .BITS (BANK_BITS),
      .ROWS (ROWS),
      .REV  (REV_MASK[b*BANK_BITS +: BANK_BITS])
    ) u_bank (
      .row_sel (row_sel),
      .col_sel (csel),
      .dout    (raw[b*BANK_BITS +: BANK_BITS])
    );
  end

  // next state: an unselected precharged line reads as one
  always_comb begin
    word_d = oor_c ? '1 : raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uinst     <= '0;
      addr_oor  <= 1'b0;
      uinst_vld <= 1'b0;
    end else begin
      uinst_vld <= rd_en;
      if (rd_en) begin
        uinst    <= word_d;
        addr_oor <= oor_c;
      end
    end
  end

  // R2: valid follows the strobe by one cycle
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> uinst_vld);
  a_r2_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !uinst_vld);

  // R3: outputs hold while idle
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ($stable(uinst) && $stable(addr_oor)));

  // R7: out-of-range read returns all ones with the flag
  a_r7_oor_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr[ADDR_W-1 -: GRP_W] >= GRP_W'(N_GRP))) |=> (addr_oor && (uinst == '1)));
  a_r7_inrange: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr[ADDR_W-1 -: GRP_W] < GRP_W'(N_GRP))) |=> !addr_oor);

endmodule

// File: tb/mrom_read_path_test.sv
module mrom_read_path_test;
  localparam logic [89:0] TB_MASK = {3{30'h2D5A1C3F}};

  logic        clk;
  logic        rst_n;
  logic        rd_en;
  logic [12:0] rd_addr;
  logic [89:0] uinst;
  logic        uinst_vld;
  logic        addr_oor;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  mrom_read_path #(.REV_MASK(TB_MASK)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .uinst     (uinst),
    .uinst_vld (uinst_vld),
    .addr_oor  (addr_oor)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected word built from the stated hash and mask
  function automatic logic [89:0] model(input logic [12:0] a);
    logic [89:0] w;
    int r, s, c, sc, b, k, v, p;
    if (int'(a[12:7]) >= 36) return '1;
    r = int'(a[12:4]);
    s = int'(a[3:0]);
    for (int n = 0; n < 90; n++) begin
      b  = n / 45;
      k  = n % 45;
      sc = TB_MASK[n] ? 15 - s : s;
      c  = k * 16 + sc;
      v  = ((r * 29) ^ (c * 7) ^ (b * 1365)) & 4095;
      p  = 0;
      for (int i = 0; i < 12; i++) p = p ^ ((v >> i) & 1);
      w[n] = p[0];
    end
    return w;
  endfunction

  task automatic chk_word(input string req, input logic [89:0] got, input logic [89:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s word got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk_bit(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%b exp=%b", req, what, got, exp);
    end
  endtask

  // one read; checks data, valid and flag in the following cycle
  task automatic do_read(input string req, input logic [12:0] a);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk_word(req, uinst, model(a));
    chk_bit(req, "vld", uinst_vld, 1'b1);
    chk_bit(req, "oor", addr_oor, int'(a[12:7]) >= 36);
  endtask

  task automatic t_reset;
    chk_word("R1", uinst, '0);
    chk_bit("R1", "vld", uinst_vld, 1'b0);
    chk_bit("R1", "oor", addr_oor, 1'b0);
  endtask

  task automatic t_contents;
    // R5 R4: several field patterns
    do_read("R5", {6'd0, 3'd0, 4'd0});
    do_read("R5", {6'd5, 3'd3, 4'd7});
    do_read("R4", {6'd17, 3'd6, 4'd9});
    do_read("R5", 13'h0A5C);
    do_read("R4", {6'd35, 3'd0, 4'd2});
  endtask

  task automatic t_bounds;
    // R8: lowest and highest rows, both column extremes
    do_read("R8", {6'd0, 3'd0, 4'd15});
    do_read("R8", {6'd35, 3'd7, 4'd0});
    do_read("R8", {6'd35, 3'd7, 4'd15});
  endtask

  task automatic t_mirror;
    // R6: masked groups read the opposite column
    do_read("R6", {6'd12, 3'd4, 4'd1});
    do_read("R6", {6'd12, 3'd4, 4'd14});
  endtask

  task automatic t_oor;
    // R7: first and last unpopulated groups
    do_read("R7", {6'd36, 3'd0, 4'd0});
    do_read("R7", {6'd63, 3'd7, 4'd15});
    do_read("R7", {6'd1, 3'd1, 4'd1});
  endtask

  task automatic t_hold;
    logic [89:0] w;
    do_read("R3", {6'd9, 3'd2, 4'd5});
    w = model({6'd9, 3'd2, 4'd5});
    rd_addr = {6'd40, 3'd0, 4'd0};
    @(negedge clk);
    chk_word("R3", uinst, w);
    chk_bit("R3", "oor", addr_oor, 1'b0);
    chk_bit("R2", "vld idle", uinst_vld, 1'b0);
  endtask

  task automatic t_stream;
    // R2: reads on consecutive cycles
    logic [12:0] prev;
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = 13'h0100;
    prev    = rd_addr;
    for (int i = 1; i < 6; i++) begin
      @(negedge clk);
      chk_word("R2", uinst, model(prev));
      chk_bit("R2", "vld stream", uinst_vld, 1'b1);
      rd_addr = prev + 13'h0137;
      prev    = rd_addr;
    end
    @(negedge clk);
    rd_en = 1'b0;
    chk_word("R2", uinst, model(prev));
  endtask

  initial begin
    rst_n   = 1'b0;
    rd_en   = 1'b0;
    rd_addr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_contents();
    t_bounds();
    t_mirror();
    t_oor();
    t_hold();
    t_stream();
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule